// File: doc/BRIEF.md
# Acknowledged Packet Transaction Sequencer

This block is the control state machine that carries out a complete acknowledged radio exchange without help from the host. For a transmit exchange, the host loads the payload and length elsewhere and then pulses a go strobe. The sequencer then brings up the crystal oscillator and waits for its power-up-done flag. It enables the synthesizer and lets it settle for a fixed number of cycles. Next it asks the framer to send the buffered data frame, turns the receiver on and waits for an acknowledge frame. The exchange finishes when that acknowledge arrives or when a programmable wait runs out. A configuration bit picks whether the block then rests in sleep (oscillator off) or idle (oscillator on).

In receive exchange mode the sequencer goes through the same start-up and then listens. Each data frame with a good CRC is committed to the receive buffer and raises an interrupt. The block answers it at once with an acknowledge frame and then listens again. Frames with a bad CRC and acknowledge frames neither reach the buffer nor get a reply. Sticky status bits report how the exchange ended and are cleared when the host reads them. The framer, the buffers and the RF path are outside the block. It talks to them only through start/done and frame-valid handshakes.

Top module: `txn_sequencer`

## Requirements
- R1: After reset the block is asleep: in_sleep=1, osc_en=0, busy=0, status=0, irq=0, fr_tx_start=0, fr_rx_en=0.
- R2: tx_go starts an exchange only from sleep or idle. While busy=1 a tx_go pulse is ignored.
- R3: Start-up order. osc_en rises first. synth_en stays 0 until osc_ready=1. synth_en is then high with fr_tx_start=0 for exactly SETTLE_CYCLES+1 cycles. Next, fr_tx_start=1 with fr_tx_ack_sel=0 (data frame from the transmit buffer) until fr_tx_done, and fr_rx_en=1 in the following cycle.
- R4: While waiting for the acknowledge, with no valid acknowledge, fr_rx_en stays high for exactly ack_wait_cycles+1 cycles. The exchange then ends with status = 4'b0101 (bit0 done, bit2 timeout).
- R5: A frame with fr_rx_valid=1, fr_rx_crc_ok=1 and fr_rx_is_ack=1 during the wait ends the exchange in the next cycle with status = 4'b0011 (bit0 done, bit1 acknowledged). This also holds in the last wait cycle, where it wins over the timeout. An acknowledge with a bad CRC is ignored.
- R6: When an exchange ends, cfg_end_idle=1 gives idle (in_sleep=0, osc_en=1) and cfg_end_idle=0 gives sleep (in_sleep=1, osc_en=0). In both cases busy=0.
- R7: With cfg_rx_txn=1 while sleeping or idle, the block starts up and listens (fr_rx_en=1). Lowering cfg_rx_txn while listening ends the exchange as in R6.
- R8: A listened data frame (valid, CRC good, fr_rx_is_ack=0) gives, in the next cycle, a one-cycle rx_buf_commit together with fr_tx_start=1 and fr_tx_ack_sel=1. After fr_tx_done the block listens again.
- R9: Acknowledge frames never change the buffers. A received acknowledge never pulses rx_buf_commit, and a sent acknowledge always has fr_tx_ack_sel=1.
- R10: A committed data frame sets status bit3. irq is the OR of all status bits.
- R11: Status bits are sticky. A stat_rd pulse clears them all in the next cycle.
- R12: A listened frame with fr_rx_crc_ok=0 gives no commit and no acknowledge, and the block keeps listening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | One-cycle strobe that starts a transmit exchange |
| cfg_rx_txn | input | 1 | Receive exchange mode enable |
| cfg_end_idle | input | 1 | End state select: 1 idle, 0 sleep |
| ack_wait_cycles | input | TW | Acknowledge wait length in cycles |
| osc_en | output | 1 | Crystal oscillator enable |
| osc_ready | input | 1 | Oscillator power-up done |
| synth_en | output | 1 | Synthesizer enable |
| fr_tx_start | output | 1 | Framer send request, held until fr_tx_done |
| fr_tx_ack_sel | output | 1 | 1: send built-in acknowledge frame, 0: send transmit buffer |
| fr_tx_done | input | 1 | Framer finished sending |
| fr_rx_en | output | 1 | Receiver enable |
| fr_rx_valid | input | 1 | Framer reports a complete received frame |
| fr_rx_crc_ok | input | 1 | CRC of the reported frame is good |
| fr_rx_is_ack | input | 1 | Reported frame is an acknowledge |
| rx_buf_commit | output | 1 | One-cycle pulse committing a received payload to the buffer |
| stat_rd | input | 1 | Host status read strobe (clears status) |
| status | output | 4 | {rx packet, timeout, acknowledged, done} |
| irq | output | 1 | Interrupt request |
| in_sleep | output | 1 | Block is in sleep |
| busy | output | 1 | Exchange in progress |

## Verification
The bench builds the block with TW=8 and SETTLE_CYCLES=3. The settle window is then short enough to count cycle by cycle. Wait lengths from 0 up to 7 can be driven, so the zero-length wait, an acknowledge in the very first wait cycle and one in the very last wait cycle all fall within a few cycles. The small settle value also keeps each exchange short, which leaves room to exercise receive mode with good, bad-CRC and acknowledge frames in one run.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_IDLE,
        ST_OSC,
        ST_SETTLE,
        ST_TX_DATA,
        ST_ACK_WAIT,
        ST_LISTEN,
        ST_TX_ACK
    } seq_state_e;

    localparam int unsigned STAT_W    = 4;
    localparam int unsigned BIT_DONE  = 0;
    localparam int unsigned BIT_ACKOK = 1;
    localparam int unsigned BIT_TMO   = 2;
    localparam int unsigned BIT_RXPKT = 3;
endpackage

// File: rtl/txn_timer.sv
module txn_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt   = load_val;
            tmr_d.armed = 1'b1;
        end else if (tmr_q.armed && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = tmr_q.armed && (tmr_q.cnt == '0);

    // R4: a fresh load reports expiry at once only for a zero length
    p_load_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (expired == ($past(load_val) == '0)))
        else $error("p_load_len_r4");
endmodule

// File: rtl/txn_status.sv
module txn_status
    import txn_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set,
    input  logic              rd,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = rd ? '0 : stat_q;
        stat_d = stat_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat = stat_q;

    p_clear_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (set == '0)) |=> (stat == '0))
        else $error("p_clear_on_read_r11");

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((stat & $past(stat)) == $past(stat)))
        else $error("p_sticky_r11");
endmodule

// File: rtl/txn_sequencer.sv
module txn_sequencer
    import txn_seq_pkg::*;
#(
    parameter int unsigned TW            = 8,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_go,
    input  logic              cfg_rx_txn,
    input  logic              cfg_end_idle,
    input  logic [TW-1:0]     ack_wait_cycles,
    output logic              osc_en,
    input  logic              osc_ready,
    output logic              synth_en,
    output logic              fr_tx_start,
    output logic              fr_tx_ack_sel,
    input  logic              fr_tx_done,
    output logic              fr_rx_en,
    input  logic              fr_rx_valid,
    input  logic              fr_rx_crc_ok,
    input  logic              fr_rx_is_ack,
    output logic              rx_buf_commit,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              in_sleep,
    output logic              busy
);
    localparam logic [TW-1:0] SETTLE_VAL = TW'(SETTLE_CYCLES);

    typedef struct packed {
        seq_state_e state;
        logic       rx_mode;
        logic       commit;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic [STAT_W-1:0] stat_set;
    logic              ack_hit, data_hit;
    seq_state_e        end_st;

    assign ack_hit  = fr_rx_valid && fr_rx_crc_ok && fr_rx_is_ack;
    assign data_hit = fr_rx_valid && fr_rx_crc_ok && !fr_rx_is_ack;
    assign end_st   = cfg_end_idle ? ST_IDLE : ST_SLEEP;

    always_comb begin
        seq_d        = seq_q;
        seq_d.commit = 1'b0;
        stat_set     = '0;
        tmr_load     = 1'b0;
        tmr_val      = SETTLE_VAL;
        unique case (seq_q.state)
            ST_SLEEP, ST_IDLE: begin
                if (tx_go) begin
                    seq_d.state   = ST_OSC;
                    seq_d.rx_mode = 1'b0;
                end else if (cfg_rx_txn) begin
                    seq_d.state   = ST_OSC;
                    seq_d.rx_mode = 1'b1;
                end
            end
            ST_OSC: begin
                if (osc_ready) begin
                    seq_d.state = ST_SETTLE;
                    tmr_load    = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) seq_d.state = seq_q.rx_mode ? ST_LISTEN : ST_TX_DATA;
            end
            ST_TX_DATA: begin
                if (fr_tx_done) begin
                    seq_d.state = ST_ACK_WAIT;
                    tmr_load    = 1'b1;
                    tmr_val     = ack_wait_cycles;
                end
            end
            ST_ACK_WAIT: begin
                if (ack_hit) begin
                    seq_d.state         = end_st;
                    stat_set[BIT_DONE]  = 1'b1;
                    stat_set[BIT_ACKOK] = 1'b1;
                end else if (tmr_expired) begin
                    seq_d.state        = end_st;
                    stat_set[BIT_DONE] = 1'b1;
                    stat_set[BIT_TMO]  = 1'b1;
                end
            end
            ST_LISTEN: begin
                if (data_hit) begin
                    seq_d.state         = ST_TX_ACK;
                    seq_d.commit        = 1'b1;
                    stat_set[BIT_RXPKT] = 1'b1;
                end else if (!cfg_rx_txn) begin
                    seq_d.state = end_st;
                end
            end
            ST_TX_ACK: begin
                if (fr_tx_done) seq_d.state = ST_LISTEN;
            end
            default: seq_d.state = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_SLEEP, rx_mode: 1'b0, commit: 1'b0};
        else        seq_q <= seq_d;
    end

    txn_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    txn_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .rd    (stat_rd),
        .stat  (status)
    );

    assign osc_en        = (seq_q.state != ST_SLEEP);
    assign synth_en      = (seq_q.state == ST_SETTLE) || (seq_q.state == ST_TX_DATA) ||
                           (seq_q.state == ST_ACK_WAIT) || (seq_q.state == ST_LISTEN) ||
                           (seq_q.state == ST_TX_ACK);
    assign fr_tx_start   = (seq_q.state == ST_TX_DATA) || (seq_q.state == ST_TX_ACK);
    assign fr_tx_ack_sel = (seq_q.state == ST_TX_ACK);
    assign fr_rx_en      = (seq_q.state == ST_ACK_WAIT) || (seq_q.state == ST_LISTEN);
    assign rx_buf_commit = seq_q.commit;
    assign in_sleep      = (seq_q.state == ST_SLEEP);
    assign busy          = (seq_q.state != ST_SLEEP) && (seq_q.state != ST_IDLE);
    assign irq           = |status;

    p_tx_after_synth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fr_tx_start) |-> $past(synth_en))
        else $error("p_tx_after_synth_r3");

    p_data_then_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_tx_start && !fr_tx_ack_sel && fr_tx_done) |=> fr_rx_en)
        else $error("p_data_then_wait_r3");

    p_tmo_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[BIT_TMO]) |-> !busy)
        else $error("p_tmo_ends_r4");

    p_end_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (in_sleep == !$past(cfg_end_idle)))
        else $error("p_end_state_r6");

    p_ack_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_commit |-> (fr_tx_start && fr_tx_ack_sel))
        else $error("p_ack_reply_r8");

    p_no_ack_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_commit |-> $past(fr_rx_valid && fr_rx_crc_ok && !fr_rx_is_ack))
        else $error("p_no_ack_commit_r9");

    p_irq_on_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_commit |-> irq)
        else $error("p_irq_on_rx_r10");
endmodule

// File: tb/txn_sequencer_bench.sv
module txn_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 8;
    localparam int SETTLE     = 3;

    // {end_idle[21], wait[20:13], ack_delay[12:5] (FF = none), ack_crc[4], exp_status[3:0]}
    localparam int NVEC = 6;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b1, 8'd5, 8'd2,   1'b1, 4'b0011},
        {1'b0, 8'd4, 8'hFF,  1'b1, 4'b0101},
        {1'b1, 8'd6, 8'd3,   1'b0, 4'b0101},
        {1'b0, 8'd3, 8'd3,   1'b1, 4'b0011},
        {1'b1, 8'd0, 8'hFF,  1'b1, 4'b0101},
        {1'b0, 8'd7, 8'd0,   1'b1, 4'b0011}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_go = 1'b0, cfg_rx_txn = 1'b0, cfg_end_idle = 1'b0;
    logic [TW-1:0] ack_wait_cycles = '0;
    logic osc_en, osc_ready = 1'b1, synth_en;
    logic fr_tx_start, fr_tx_ack_sel, fr_tx_done = 1'b0, fr_rx_en;
    logic fr_rx_valid = 1'b0, fr_rx_crc_ok = 1'b0, fr_rx_is_ack = 1'b0;
    logic rx_buf_commit, stat_rd = 1'b0, irq, in_sleep, busy;
    logic [3:0] status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_sequencer #(.TW(TW), .SETTLE_CYCLES(SETTLE)) u_txn_sequencer (
        .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .cfg_rx_txn(cfg_rx_txn),
        .cfg_end_idle(cfg_end_idle), .ack_wait_cycles(ack_wait_cycles),
        .osc_en(osc_en), .osc_ready(osc_ready), .synth_en(synth_en),
        .fr_tx_start(fr_tx_start), .fr_tx_ack_sel(fr_tx_ack_sel), .fr_tx_done(fr_tx_done),
        .fr_rx_en(fr_rx_en), .fr_rx_valid(fr_rx_valid), .fr_rx_crc_ok(fr_rx_crc_ok),
        .fr_rx_is_ack(fr_rx_is_ack), .rx_buf_commit(rx_buf_commit), .stat_rd(stat_rd),
        .status(status), .irq(irq), .in_sleep(in_sleep), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R11 status cleared by read", int'(status), 0);
    endtask

    task automatic run_tx(input logic idle, input logic [7:0] w, input logic [7:0] dly,
                          input logic crc, input logic [3:0] exp);
        int n;
        int waitc;
        int expw;
        logic saw_commit;
        cfg_end_idle    = idle;
        ack_wait_cycles = w;
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
        n = 0;
        while (!fr_tx_start && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R3 data frame requested", int'(fr_tx_start), 1);
        chk("R3 data frame uses transmit buffer", int'(fr_tx_ack_sel), 0);
        fr_tx_done = 1'b1;
        @(negedge clk);
        fr_tx_done = 1'b0;
        chk("R3 receiver on after data frame", int'(fr_rx_en), 1);
        waitc = 0;
        saw_commit = 1'b0;
        while (fr_rx_en && waitc < 300) begin
            if (waitc == int'(dly)) begin
                fr_rx_valid  = 1'b1;
                fr_rx_crc_ok = crc;
                fr_rx_is_ack = 1'b1;
            end
            if (rx_buf_commit) saw_commit = 1'b1;
            @(negedge clk);
            fr_rx_valid = 1'b0;
            waitc++;
        end
        expw = (crc && dly <= w) ? int'(dly) + 1 : int'(w) + 1;
        chk("R4 R5 wait length", waitc, expw);
        chk("R4 R5 end status", int'(status), int'(exp));
        chk("R6 busy cleared", int'(busy), 0);
        chk("R6 end state sleep flag", int'(in_sleep), int'(!idle));
        chk("R6 oscillator in end state", int'(osc_en), int'(idle));
        chk("R9 no commit from acknowledge", int'(saw_commit), 0);
        chk("R10 irq follows status", int'(irq), 1);
        @(negedge clk);
        chk("R11 status sticky", int'(status), int'(exp));
        read_status();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_sleep", int'(in_sleep), 1);
        chk("R1 reset osc_en", int'(osc_en), 0);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset framer idle", int'(fr_tx_start | fr_rx_en), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_tx(VEC[i][21], VEC[i][20:13], VEC[i][12:5], VEC[i][4], VEC[i][3:0]);
        end

        // R3: start-up order with a slow oscillator, from sleep
        osc_ready = 1'b0;
        cfg_end_idle = 1'b0;
        ack_wait_cycles = 8'd2;
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R3 oscillator on", int'(osc_en), 1);
            chk("R3 synth waits for oscillator", int'(synth_en), 0);
            @(negedge clk);
        end
        osc_ready = 1'b1;
        @(negedge clk);
        n = 0;
        while (!fr_tx_start && n < 50) begin
            if (synth_en) n++;
            @(negedge clk);
        end
        chk("R3 settle cycles", n, SETTLE + 1);
        fr_tx_done = 1'b1;
        @(negedge clk);
        fr_tx_done = 1'b0;
        chk("R3 receiver on after send", int'(fr_rx_en), 1);
        // R2: go strobe ignored while busy
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
        chk("R2 go ignored while busy", int'(fr_tx_start), 0);
        n = 0;
        while (busy && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R4 timeout status", int'(status), 5);
        read_status();

        // Receive exchange mode
        cfg_rx_txn = 1'b1;
        n = 0;
        while (!fr_rx_en && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R7 listening", int'(fr_rx_en), 1);
        tx_go = 1'b1;
        @(negedge clk);
        tx_go = 1'b0;
        chk("R2 go ignored while listening", int'(fr_tx_start), 0);
        chk("R2 still listening", int'(fr_rx_en), 1);

        fr_rx_valid = 1'b1; fr_rx_crc_ok = 1'b0; fr_rx_is_ack = 1'b0;
        @(negedge clk);
        fr_rx_valid = 1'b0;
        chk("R12 bad CRC no commit", int'(rx_buf_commit), 0);
        chk("R12 bad CRC no acknowledge", int'(fr_tx_start), 0);
        chk("R12 bad CRC keeps listening", int'(fr_rx_en), 1);
        chk("R12 bad CRC no status", int'(status), 0);

        fr_rx_valid = 1'b1; fr_rx_crc_ok = 1'b1; fr_rx_is_ack = 1'b1;
        @(negedge clk);
        fr_rx_valid = 1'b0;
        chk("R9 received acknowledge no commit", int'(rx_buf_commit), 0);
        chk("R9 received acknowledge keeps listening", int'(fr_rx_en), 1);

        fr_rx_valid = 1'b1; fr_rx_crc_ok = 1'b1; fr_rx_is_ack = 1'b0;
        @(negedge clk);
        fr_rx_valid = 1'b0;
        chk("R8 commit pulse", int'(rx_buf_commit), 1);
        chk("R8 acknowledge sent", int'(fr_tx_start), 1);
        chk("R9 acknowledge frame selected", int'(fr_tx_ack_sel), 1);
        chk("R10 rx status bit", int'(status), 8);
        chk("R10 irq raised", int'(irq), 1);
        @(negedge clk);
        chk("R8 commit is one cycle", int'(rx_buf_commit), 0);
        chk("R8 acknowledge held until done", int'(fr_tx_start), 1);
        fr_tx_done = 1'b1;
        @(negedge clk);
        fr_tx_done = 1'b0;
        chk("R8 back to listening", int'(fr_rx_en), 1);
        chk("R8 acknowledge released", int'(fr_tx_start), 0);
        read_status();
        chk("R11 irq cleared", int'(irq), 0);

        cfg_rx_txn = 1'b0;
        cfg_end_idle = 1'b1;
        @(negedge clk);
        chk("R7 receive mode ends", int'(busy), 0);
        chk("R6 rests in idle", int'(in_sleep), 0);
        chk("R6 oscillator kept in idle", int'(osc_en), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule